// File: doc/BRIEF.md
# Register-Mapped SPI Master

A single-word SPI master that sits on a plain 32-bit register bus. Software writes a
control word that picks the clock mode, which of four chip-select lines to use, whether
chip select is driven by hardware or held by software, bit and byte ordering, the
receive and transmit enables and the word length (1 to 32 bits). It then writes one
word into the transmit queue and writes the control word again with the start bit set.
The engine shifts the word out on `sclk`/`mosi`, samples `miso` into a receive queue,
clears the start bit and raises a ready flag that software clears by writing 1.

Data moves between the register bus and the shifter through two small queues with a
valid/ready handshake. Back-pressure is never passed to software: a write into a full
transmit queue or a read from an empty receive queue is dropped and recorded in a
sticky error flag. When the receive queue is full at the end of a transfer the
received word is dropped the same way. Error flags and the ready flag stay set until
written with 1.

Top module: `spi_ctl_top`

Register map (byte addresses): control 0x000, divider 0x004, transfer status 0x010,
queue status 0x014, transmit queue write 0x108, receive queue read 0x188 (the read pops).
Control bits: 31 start, 30 master select (stored only), 29 CPOL, 28 CPHA, 27:26
chip-select index, 21 software chip select, 20 software chip-select level, 16 LSB bit
first, 15 byte reversal, 12 receive enable, 11 transmit enable, 4:0 length minus one.

## Requirements
- R1: After reset all `cs_n` lines are high, `sclk` is low, control reads 0x0010_0000, the divider reads DIV_RESET, transfer status reads 0 and queue status reads 0x0000_0005 (TX empty bit 2, RX empty bit 0).
- R2: With bits 16 and 15 clear, a transfer of N = len+1 bits sends bits N-1..0 of the queued word MSB first; the last bit sampled lands in bit 0 of the received word, bits above N-1 read 0, and the word is pushed into the receive queue, clearing RX empty.
- R3: With bit 21 clear, only the line chosen by bits 27:26 goes low, for the whole transfer, and returns high exactly one SCLK period (2*(div+1) clocks) after the final SCLK edge; with bit 21 set, that line follows bit 20. At most one line is ever low.
- R4: The start bit (31) reads 1 while a transfer runs and clears itself when it ends; a start write while busy is ignored.
- R5: Transfer status bit 30 is set when a transfer completes and cleared by writing 1 to it.
- R6: Writing the start bit with transmit enabled and an empty transmit queue starts nothing and sets TX underrun (bit 6) and the error summary (bit 8); error flags are cleared by writing 1.
- R7: A write into a full transmit queue is dropped and sets TX overflow (bit 7) and bit 8; TX full (bit 3) reflects the queue.
- R8: A read of an empty receive queue returns 0 and sets RX underrun (bit 4); a completed word arriving at a full receive queue is dropped and sets RX overflow (bit 5); RX full is bit 1. Both set bit 8.
- R9: `sclk` idles at CPOL; with CPHA 0 data is sampled on the leading edge and changed on the trailing edge, with CPHA 1 the reverse; all four modes move data correctly.
- R10: With bit 16 set, bit 0 of the word is sent first and the first bit received lands in bit 0.
- R11: With bit 15 set, the four bytes of the 32-bit word are reversed before sending and the received word is byte-reversed before it is queued.
- R12: Each SCLK half period lasts div+1 system clocks, div being the divider register.
- R13: With transmit disabled, `mosi` stays low and the transmit queue is not popped; with receive disabled, nothing enters the receive queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 9 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (pops the receive queue at 0x188) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the access |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The bench builds the block with both queues two entries deep and a 4-bit divider
starting at 1, so the full and overflow corners on both queues are reached with two or
three words and every SCLK half period is short enough to time exactly in nanoseconds.
A bus-side device model follows CPOL/CPHA from the control word, which lets all four
modes, both bit orders, byte reversal, the 1-bit and 32-bit lengths and the chip-select
release delay be checked against values worked out by hand.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int ADDR_W = 9;

  localparam logic [ADDR_W-1:0] A_CMD   = 9'h000;
  localparam logic [ADDR_W-1:0] A_DIV   = 9'h004;
  localparam logic [ADDR_W-1:0] A_XSTAT = 9'h010;
  localparam logic [ADDR_W-1:0] A_FSTAT = 9'h014;
  localparam logic [ADDR_W-1:0] A_TXQ   = 9'h108;
  localparam logic [ADDR_W-1:0] A_RXQ   = 9'h188;

  localparam logic [31:0] CMD_MASK = 32'h7C31_981F;
  localparam logic [31:0] CMD_RST  = 32'h0010_0000;

  localparam int B_GO     = 31;
  localparam int B_CPOL   = 29;
  localparam int B_CPHA   = 28;
  localparam int B_SWCS   = 21;
  localparam int B_CSLVL  = 20;
  localparam int B_LSBIT  = 16;
  localparam int B_LSBYTE = 15;
  localparam int B_RXEN   = 12;
  localparam int B_TXEN   = 11;
  localparam int B_RDY    = 30;
  localparam int F_ERR    = 8;
  localparam int F_TXOVF  = 7;
  localparam int F_TXUNR  = 6;
  localparam int F_RXOVF  = 5;
  localparam int F_RXUNR  = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL} eng_st_e;

  function automatic logic [31:0] bit_rev32(input logic [31:0] v);
    for (int i = 0; i < 32; i++) bit_rev32[i] = v[31-i];
  endfunction

  function automatic logic [31:0] byte_rev32(input logic [31:0] v);
    byte_rev32 = {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/spi_ctl_fifo.sv
module spi_ctl_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign in_ready  = (cnt != CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rd_ptr];
  assign do_push   = in_valid && in_ready;
  assign do_pop    = out_valid && out_ready;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    nxt = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= in_data;
        wr_ptr      <= nxt(wr_ptr);
      end
      if (do_pop) rd_ptr <= nxt(rd_ptr);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !out_ready) |=> (cnt == $past(cnt))); // R7
endmodule

// File: rtl/spi_ctl_engine.sv
module spi_ctl_engine
  import spi_ctl_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [4:0]       len_m1,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             lsb_first,
  input  logic [31:0]      tx_word,
  input  logic [DIV_W-1:0] div,
  input  logic             idle_pol,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [31:0]      rx_word
);
  eng_st_e          st;
  logic [31:0]      tx_sr, rx_sr, aligned;
  logic [DIV_W-1:0] half;
  logic [6:0]       edge_n;
  logic [4:0]       len_q;
  logic             cpha_q, lsb_q, sclk_q, tail2, sample;

  assign aligned = lsb_first ? bit_rev32(tx_word) : (tx_word << (5'd31 - len_m1));
  assign sample  = ~edge_n[0] ^ cpha_q;
  assign busy    = (st != ST_IDLE);
  assign sclk    = busy ? sclk_q : idle_pol;
  assign rx_word = lsb_q ? (bit_rev32(rx_sr) >> (5'd31 - len_q)) : rx_sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; tx_sr <= '0; rx_sr <= '0; half <= '0; edge_n <= '0;
      len_q <= '0; cpha_q <= 1'b0; lsb_q <= 1'b0; sclk_q <= 1'b0;
      tail2 <= 1'b0; mosi <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          len_q  <= len_m1;
          cpha_q <= cpha;
          lsb_q  <= lsb_first;
          half   <= '0;
          edge_n <= '0;
          sclk_q <= cpol;
          rx_sr  <= '0;
          st     <= ST_SHIFT;
          if (!cpha) begin
            mosi  <= aligned[31];
            tx_sr <= aligned << 1;
          end else begin
            mosi  <= 1'b0;
            tx_sr <= aligned;
          end
        end
        ST_SHIFT: if (half == div) begin
          half   <= '0;
          sclk_q <= ~sclk_q;
          edge_n <= edge_n + 1'b1;
          if (sample) rx_sr <= {rx_sr[30:0], miso};
          else begin
            mosi  <= tx_sr[31];
            tx_sr <= tx_sr << 1;
          end
          if (edge_n == {1'b0, len_q, 1'b1}) begin
            st    <= ST_TAIL;
            tail2 <= 1'b0;
          end
        end else half <= half + 1'b1;
        ST_TAIL: if (half == div) begin
          half <= '0;
          if (tail2) begin
            st   <= ST_IDLE;
            done <= 1'b1;
            mosi <= 1'b0;
          end else tail2 <= 1'b1;
        end else half <= half + 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_SCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && half != div) |=> $stable(sclk_q)); // R12
endmodule

// File: rtl/spi_ctl_top.sv
module spi_ctl_top
  import spi_ctl_pkg::*;
#(
  parameter int TX_DEPTH  = 4,
  parameter int RX_DEPTH  = 4,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [8:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  cs_n
);
  localparam int NCS = 4;

  logic [31:0]      cmd_q, tx_head, rx_head, eng_rx, eng_tx;
  logic [DIV_W-1:0] div_q;
  logic             go_q, rdy_q, err_q, txovf_q, txunr_q, rxovf_q, rxunr_q;
  logic             wr_cmd, wr_fst, wr_xst, want_go, go_unr, eng_start;
  logic             eng_busy, eng_done, cs_lvl;
  logic             tx_push, tx_rdy, tx_val, tx_pop;
  logic             rx_push, rx_rdy, rx_val, rx_pop;
  logic             set_txovf, set_rxovf, set_rxunr, any_err;

  assign wr_cmd = reg_wr && reg_addr == A_CMD;
  assign wr_fst = reg_wr && reg_addr == A_FSTAT;
  assign wr_xst = reg_wr && reg_addr == A_XSTAT;

  assign want_go   = wr_cmd && reg_wdata[B_GO] && !go_q && !eng_busy;
  assign go_unr    = want_go && reg_wdata[B_TXEN] && !tx_val;
  assign eng_start = want_go && !go_unr;
  assign tx_pop    = eng_start && reg_wdata[B_TXEN];
  assign eng_tx    = !reg_wdata[B_TXEN] ? '0 :
                     (reg_wdata[B_LSBYTE] ? byte_rev32(tx_head) : tx_head);

  assign tx_push   = reg_wr && reg_addr == A_TXQ;
  assign rx_push   = eng_done && cmd_q[B_RXEN];
  assign rx_pop    = reg_rd && reg_addr == A_RXQ;
  assign set_txovf = tx_push && !tx_rdy;
  assign set_rxovf = rx_push && !rx_rdy;
  assign set_rxunr = rx_pop && !rx_val;
  assign any_err   = set_txovf || set_rxovf || set_rxunr || go_unr;

  spi_ctl_fifo #(.W(32), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_push), .in_ready(tx_rdy), .in_data(reg_wdata),
    .out_valid(tx_val), .out_ready(tx_pop), .out_data(tx_head));

  spi_ctl_fifo #(.W(32), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_push), .in_ready(rx_rdy),
    .in_data(cmd_q[B_LSBYTE] ? byte_rev32(eng_rx) : eng_rx),
    .out_valid(rx_val), .out_ready(rx_pop), .out_data(rx_head));

  spi_ctl_engine #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start),
    .len_m1(reg_wdata[4:0]), .cpol(reg_wdata[B_CPOL]), .cpha(reg_wdata[B_CPHA]),
    .lsb_first(reg_wdata[B_LSBIT]), .tx_word(eng_tx), .div(div_q),
    .idle_pol(cmd_q[B_CPOL]), .miso(miso), .sclk(sclk), .mosi(mosi),
    .busy(eng_busy), .done(eng_done), .rx_word(eng_rx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= CMD_RST; div_q <= DIV_W'(DIV_RESET); go_q <= 1'b0; rdy_q <= 1'b0;
      err_q <= 1'b0; txovf_q <= 1'b0; txunr_q <= 1'b0; rxovf_q <= 1'b0; rxunr_q <= 1'b0;
    end else begin
      if (wr_cmd) cmd_q <= reg_wdata & CMD_MASK;
      if (reg_wr && reg_addr == A_DIV) div_q <= reg_wdata[DIV_W-1:0];
      if (eng_start) go_q <= 1'b1;
      else if (eng_done) go_q <= 1'b0;
      rdy_q   <= eng_done  | (rdy_q   & ~(wr_xst & reg_wdata[B_RDY]));
      err_q   <= any_err   | (err_q   & ~(wr_fst & reg_wdata[F_ERR]));
      txovf_q <= set_txovf | (txovf_q & ~(wr_fst & reg_wdata[F_TXOVF]));
      txunr_q <= go_unr    | (txunr_q & ~(wr_fst & reg_wdata[F_TXUNR]));
      rxovf_q <= set_rxovf | (rxovf_q & ~(wr_fst & reg_wdata[F_RXOVF]));
      rxunr_q <= set_rxunr | (rxunr_q & ~(wr_fst & reg_wdata[F_RXUNR]));
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CMD:   reg_rdata = cmd_q | {go_q, 31'b0};
      A_DIV:   reg_rdata = 32'(div_q);
      A_XSTAT: reg_rdata = {1'b0, rdy_q, 30'b0};
      A_FSTAT: reg_rdata = {23'b0, err_q, txovf_q, txunr_q, rxovf_q, rxunr_q,
                            ~tx_rdy, ~tx_val, ~rx_rdy, ~rx_val};
      A_RXQ:   reg_rdata = rx_val ? rx_head : '0;
      default: reg_rdata = '0;
    endcase
  end

  assign cs_lvl = cmd_q[B_SWCS] ? cmd_q[B_CSLVL] : ~eng_busy;

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_n[i] = (cmd_q[27:26] == 2'(i)) ? cs_lvl : 1'b1;
  end

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1); // R3
  AST_GO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> !go_q); // R4
  AST_READY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> rdy_q); // R5
  AST_UNR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txunr_q) |-> err_q); // R6
  AST_RXOVF_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxovf_q) |-> err_q); // R8
endmodule

// File: tb/tb_spi_ctl_top.sv
module tb_spi_ctl_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        sclk, mosi, miso = 1'b0;
  logic [3:0]  cs_n;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spi_ctl_top #(.TX_DEPTH(2), .RX_DEPTH(2), .DIV_W(4), .DIV_RESET(1)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  // device model
  wire cs_act = ~&cs_n;
  logic [31:0] s_tx = '0, s_rx = '0;
  logic s_cpol = 1'b0, s_cpha = 1'b0;
  time last_e = 0, prev_e = 0, t_rel = 0;

  always @(cs_act) if (cs_act) begin
    s_rx = '0;
    if (!s_cpha) begin miso = s_tx[31]; s_tx = s_tx << 1; end
  end
  always @(sclk) if (cs_act) begin
    prev_e = last_e; last_e = $time;
    if ((sclk != s_cpol) ^ s_cpha) s_rx = {s_rx[30:0], mosi};
    else begin miso = s_tx[31]; s_tx = s_tx << 1; end
  end
  always @(negedge cs_act) t_rel = $time;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(posedge clk); #1 reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(posedge clk); #1 reg_addr = a; reg_rd = 1'b1;
    #3 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  function automatic logic [31:0] mk(input int mode, input int cs, input bit sw, input bit lvl,
      input bit lsbit, input bit lsby, input bit rx, input bit tx, input int nbits);
    mk = (32'(mode) << 28) | (32'(cs) << 26) | (32'(sw) << 21) | (32'(lvl) << 20) |
         (32'(lsbit) << 16) | (32'(lsby) << 15) | (32'(rx) << 12) | (32'(tx) << 11) |
         32'(nbits - 1);
  endfunction

  // start a transfer and wait for the ready flag
  task automatic xfer(input logic [31:0] cmd, input logic [31:0] txw, input logic [31:0] sw_,
                      input bit push, input string req);
    logic [31:0] d;
    bit got = 1'b0;
    s_cpol = cmd[29]; s_cpha = cmd[28]; s_tx = sw_;
    wr(9'h000, cmd);
    if (push) wr(9'h108, txw);
    wr(9'h000, cmd | 32'h8000_0000);
    for (int i = 0; i < 3000 && !got; i++) begin
      rd(9'h010, d);
      got = d[30];
    end
    chk(got, req, d, 32'h4000_0000);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(cs_n == 4'hF, "R1 cs_n", 32'(cs_n), 32'hF);
    chk(sclk == 1'b0, "R1 sclk", 32'(sclk), 0);
    rd(9'h000, d); chk(d == 32'h0010_0000, "R1 cmd", d, 32'h0010_0000);
    rd(9'h004, d); chk(d == 32'd1, "R1 div", d, 1);
    rd(9'h010, d); chk(d == 0, "R1 xstat", d, 0);
    rd(9'h014, d); chk(d == 32'h5, "R1 fstat", d, 32'h5);
  endtask

  task automatic t_basic;   // R2 R4 R5
    logic [31:0] d;
    xfer(mk(0, 0, 0, 1, 0, 0, 1, 1, 8), 32'hFFFF_FFA5, 32'h3C00_0000, 1, "R5 ready");
    chk(s_rx == 32'hA5, "R2 mosi bits", s_rx, 32'hA5);
    rd(9'h000, d); chk(d[31] == 1'b0, "R4 go cleared", d, 0);
    rd(9'h014, d); chk(d[0] == 1'b0, "R2 rx not empty", d, 32'h4);
    rd(9'h188, d); chk(d == 32'h3C, "R2 rx word", d, 32'h3C);
    wr(9'h010, 32'h4000_0000);
    rd(9'h010, d); chk(d == 0, "R5 ready w1c", d, 0);
    xfer(mk(0, 0, 0, 1, 0, 0, 1, 1, 32), 32'hDEAD_BEEF, 32'h1234_5678, 1, "R2 len32");
    chk(s_rx == 32'hDEAD_BEEF, "R2 len32 tx", s_rx, 32'hDEAD_BEEF);
    rd(9'h188, d); chk(d == 32'h1234_5678, "R2 len32 rx", d, 32'h1234_5678);
    wr(9'h010, 32'h4000_0000);
    xfer(mk(0, 0, 0, 1, 0, 0, 1, 1, 1), 32'h1, 32'h8000_0000, 1, "R2 len1");
    chk(s_rx == 32'h1, "R2 len1 tx", s_rx, 1);
    rd(9'h188, d); chk(d == 32'h1, "R2 len1 rx", d, 1);
    wr(9'h010, 32'h4000_0000);
  endtask

  task automatic t_cs;   // R3 R4 R12
    logic [31:0] d;
    wr(9'h000, mk(0, 2, 0, 1, 0, 0, 0, 1, 8));
    wr(9'h108, 32'h55);
    s_tx = '0; s_cpol = 0; s_cpha = 0;
    wr(9'h000, mk(0, 2, 0, 1, 0, 0, 0, 1, 8) | 32'h8000_0000);
    chk(cs_n == 4'b1011, "R3 hw cs line", 32'(cs_n), 32'hB);
    rd(9'h000, d); chk(d[31] == 1'b1, "R4 go while busy", d, 32'h8000_0000);
    repeat (60) @(posedge clk);
    chk(t_rel - last_e == 40, "R3 release delay", 32'(t_rel - last_e), 40);
    chk(last_e - prev_e == 20, "R12 half period div1", 32'(last_e - prev_e), 20);
    wr(9'h010, 32'h4000_0000);
    wr(9'h000, mk(0, 1, 1, 0, 0, 0, 0, 0, 8));
    #2 chk(cs_n == 4'b1101, "R3 sw cs low", 32'(cs_n), 32'hD);
    wr(9'h000, mk(0, 1, 1, 1, 0, 0, 0, 0, 8));
    #2 chk(cs_n == 4'hF, "R3 sw cs high", 32'(cs_n), 32'hF);
    wr(9'h004, 32'd3);
    xfer(mk(0, 0, 0, 1, 0, 0, 0, 1, 8), 32'h0F, 32'h0, 1, "R12 xfer");
    chk(last_e - prev_e == 40, "R12 half period div3", 32'(last_e - prev_e), 40);
    wr(9'h004, 32'd1);
    wr(9'h010, 32'h4000_0000);
  endtask

  task automatic t_modes;   // R9
    logic [31:0] d;
    for (int m = 1; m < 4; m++) begin
      xfer(mk(m, 0, 0, 1, 0, 0, 1, 1, 8), 32'h96, 32'h5A00_0000, 1, "R9 ready");
      chk(s_rx == 32'h96, $sformatf("R9 mode%0d tx", m), s_rx, 32'h96);
      rd(9'h188, d); chk(d == 32'h5A, $sformatf("R9 mode%0d rx", m), d, 32'h5A);
      chk(sclk == m[1], "R9 idle level", 32'(sclk), 32'(m[1]));
      wr(9'h010, 32'h4000_0000);
    end
    wr(9'h000, mk(0, 0, 0, 1, 0, 0, 0, 0, 8));
  endtask

  task automatic t_order;   // R10 R11
    logic [31:0] d;
    xfer(mk(0, 0, 0, 1, 1, 0, 1, 1, 8), 32'h12, 32'hB000_0000, 1, "R10 ready");
    chk(s_rx == 32'h48, "R10 lsb tx", s_rx, 32'h48);
    rd(9'h188, d); chk(d == 32'h0D, "R10 lsb rx", d, 32'h0D);
    wr(9'h010, 32'h4000_0000);
    xfer(mk(0, 0, 0, 1, 0, 1, 1, 1, 32), 32'h1122_3344, 32'hAABB_CCDD, 1, "R11 ready");
    chk(s_rx == 32'h4433_2211, "R11 byte tx", s_rx, 32'h4433_2211);
    rd(9'h188, d); chk(d == 32'hDDCC_BBAA, "R11 byte rx", d, 32'hDDCC_BBAA);
    wr(9'h010, 32'h4000_0000);
  endtask

  task automatic t_errors;   // R6 R7 R8
    logic [31:0] d;
    wr(9'h000, mk(0, 0, 0, 1, 0, 0, 1, 1, 8) | 32'h8000_0000);
    rd(9'h014, d); chk(d == 32'h145, "R6 underrun", d, 32'h145);
    rd(9'h000, d); chk(d[31] == 1'b0, "R6 no start", d, 0);
    chk(cs_n == 4'hF, "R6 no cs", 32'(cs_n), 32'hF);
    wr(9'h014, 32'h140);
    rd(9'h014, d); chk(d == 32'h5, "R6 w1c", d, 32'h5);
    wr(9'h108, 32'h11); wr(9'h108, 32'h22); wr(9'h108, 32'h33);
    rd(9'h014, d); chk(d == 32'h189, "R7 overflow full", d, 32'h189);
    wr(9'h014, 32'h180);
    xfer(mk(0, 0, 0, 1, 0, 0, 1, 1, 8), 0, 32'hA100_0000, 0, "R7 x1");
    chk(s_rx == 32'h11, "R7 first kept", s_rx, 32'h11);
    wr(9'h010, 32'h4000_0000);
    xfer(mk(0, 0, 0, 1, 0, 0, 1, 1, 8), 0, 32'hA200_0000, 0, "R7 x2");
    chk(s_rx == 32'h22, "R7 third dropped", s_rx, 32'h22);
    wr(9'h010, 32'h4000_0000);
    rd(9'h014, d); chk(d == 32'h6, "R8 rx full", d, 32'h6);
    xfer(mk(0, 0, 0, 1, 0, 0, 1, 1, 8), 32'h77, 32'hA300_0000, 1, "R8 x3");
    rd(9'h014, d); chk(d == 32'h126, "R8 rx overflow", d, 32'h126);
    rd(9'h188, d); chk(d == 32'hA1, "R8 rx0", d, 32'hA1);
    rd(9'h188, d); chk(d == 32'hA2, "R8 rx1", d, 32'hA2);
    rd(9'h188, d); chk(d == 0, "R8 underrun data", d, 0);
    rd(9'h014, d); chk(d == 32'h135, "R8 rx underrun", d, 32'h135);
    wr(9'h014, 32'h1F0);
    wr(9'h010, 32'h4000_0000);
  endtask

  task automatic t_disable;   // R13
    logic [31:0] d;
    wr(9'h108, 32'hFF);
    xfer(mk(0, 0, 0, 1, 0, 0, 1, 0, 8), 0, 32'hC300_0000, 0, "R13 tx off");
    chk(s_rx == 0, "R13 mosi low", s_rx, 0);
    rd(9'h014, d); chk(d == 32'h0, "R13 tx kept", d, 32'h0);
    rd(9'h188, d); chk(d == 32'hC3, "R13 rx word", d, 32'hC3);
    wr(9'h010, 32'h4000_0000);
    xfer(mk(0, 0, 0, 1, 0, 0, 0, 1, 8), 0, 32'h9900_0000, 0, "R13 rx off");
    chk(s_rx == 32'hFF, "R13 queued word sent", s_rx, 32'hFF);
    rd(9'h014, d); chk(d == 32'h5, "R13 rx stays empty", d, 32'h5);
    wr(9'h010, 32'h4000_0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_cs();
    t_modes();
    t_order();
    t_errors();
    t_disable();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule